// File: doc/BRIEF.md
# Signed Multicycle Functional Unit

This block is an arithmetic functional unit for W-bit two's-complement operands (W = 8 by default). A 2-bit opcode, sampled with a start strobe, picks one of three operations: integer power, addition, or bitwise OR. A fourth code passes operand `a` through unchanged.

Addition, OR and pass-through complete on the clock edge that accepts start. Power repeats a multiplication, one per cycle, and the number of steps is the exponent. Every result is truncated to W bits.

A single-cycle `done` pulse marks each completion. `result` holds its value between completions. While a power operation is running, start is ignored and the operand inputs may change freely.

Top module: `fu_top`

## Requirements
- R1: While `rst_n` is low, `done` is 0 and `result` is 0. The reset acts at once, without a clock edge, and also aborts a power operation in progress.
- R2: Opcode 2'b01 yields `result` = (a + b) mod 2^W. Operands are two's complement, so the sum wraps with no saturation.
- R3: Opcode 2'b10 yields `result` = a | b, bit by bit.
- R4: Opcode 2'b11 yields `result` = a, unchanged.
- R5: Opcode 2'b00 yields `result` = a^e mod 2^W. The exponent e is the low W-1 bits of `b`, and the top bit of `b` is ignored. Because `a` is signed, odd exponents keep its sign, for example (-2)^3 = -8.
- R6: A power operation with e = 0 yields 1 for every `a`, including `a` = 0.
- R7: Latency is counted from the clock edge that samples start. For opcodes 01, 10 and 11, `done` is high in the cycle that begins at that edge. For opcode 00, `done` is high in the cycle that begins e+1 edges later.
- R8: `done` lasts exactly one cycle per operation. `result` changes only together with a `done` pulse and holds otherwise.
- R9: Start is ignored while a power operation is in progress. The operands are captured at acceptance, so changing `start`, `op`, `a` or `b` during the operation does not alter its result or its latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an operation; accepted only when idle |
| op | input | 2 | Operation: 00 power, 01 add, 10 OR, 11 pass `a` |
| a | input | W | First operand, two's complement (power base) |
| b | input | W | Second operand; for power, low W-1 bits are the exponent |
| result | output | W | Result of the most recent completed operation |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench builds two copies of the unit.

The first uses W = 4. At that width, every opcode can be run with every pair of operands, so every wrap of sum and product is covered, along with every sign combination and every exponent from 0 to 7.

The second uses the default W = 8. It covers all 256 bases against exponents of 0, 1, 2 and 3, the largest exponent 127, and a `b` with its top bit set. The add, OR and pass codes are run against a spread of second operands.

In both copies the operands are scrambled and start is held high during every power operation. An asynchronous reset is also applied in the middle of a long power operation.

// File: rtl/fu_pkg.sv
package fu_pkg;
  typedef enum logic [1:0] {
    OP_POW  = 2'b00,
    OP_ADD  = 2'b01,
    OP_OR   = 2'b10,
    OP_PASS = 2'b11
  } fu_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } fu_state_e;
endpackage

// File: rtl/fu_quick_alu.sv
module fu_quick_alu #(
  parameter int W = 8
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  import fu_pkg::*;

  logic [W-1:0] sum_v;
  logic [W-1:0] or_v;

  assign sum_v = a + b;

  for (genvar i = 0; i < W; i++) begin : g_or
    assign or_v[i] = a[i] | b[i];
  end

  always_comb begin
    unique case (fu_op_e'(op))
      OP_ADD:  y = sum_v;
      OP_OR:   y = or_v;
      OP_PASS: y = a;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/fu_pow_dp.sv
module fu_pow_dp #(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [W-1:0]  acc,
  output logic [W-2:0]  cnt,
  output logic          cnt_zero
);
  localparam int EW = W - 1;
  localparam logic [W-1:0]  ACC_ONE = W'(1);
  localparam logic [EW-1:0] CNT_ONE = EW'(1);

  logic [W-1:0]  acc_q,  acc_d;
  logic [W-1:0]  base_q, base_d;
  logic [EW-1:0] cnt_q,  cnt_d;
  logic          en;

  assign en = load | step;

  always_comb begin
    acc_d  = acc_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load) begin
      acc_d  = ACC_ONE;
      base_d = a;
      cnt_d  = b[EW-1:0];
    end else if (step) begin
      acc_d  = acc_q * base_q;
      cnt_d  = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      acc_q  <= acc_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign acc      = acc_q;
  assign cnt      = cnt_q;
  assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/fu_ctrl.sv
module fu_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] op,
  input  logic       cnt_zero,
  output logic       busy,
  output logic       fast_fire,
  output logic       pow_load,
  output logic       pow_step,
  output logic       pow_finish
);
  import fu_pkg::*;

  fu_state_e state_q, state_d;
  logic      accept;

  assign busy       = (state_q == ST_BUSY);
  assign accept     = (state_q == ST_IDLE) && start;
  assign fast_fire  = accept && (fu_op_e'(op) != OP_POW);
  assign pow_load   = accept && (fu_op_e'(op) == OP_POW);
  assign pow_step   = busy && !cnt_zero;
  assign pow_finish = busy && cnt_zero;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (pow_load)   state_d = ST_BUSY;
      ST_BUSY: if (pow_finish) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/fu_top.sv
module fu_top #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic         done
);
  logic         busy;
  logic         fast_fire;
  logic         pow_load;
  logic         pow_step;
  logic         pow_finish;
  logic         cnt_zero;
  logic [W-2:0] pow_cnt;
  logic [W-1:0] pow_acc;
  logic [W-1:0] quick_y;

  logic [W-1:0] result_q, result_d;
  logic         done_q,   done_d;

  fu_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op         (op),
    .cnt_zero   (cnt_zero),
    .busy       (busy),
    .fast_fire  (fast_fire),
    .pow_load   (pow_load),
    .pow_step   (pow_step),
    .pow_finish (pow_finish)
  );

  fu_pow_dp #(.W(W)) u_pow (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (pow_load),
    .step     (pow_step),
    .a        (a),
    .b        (b),
    .acc      (pow_acc),
    .cnt      (pow_cnt),
    .cnt_zero (cnt_zero)
  );

  fu_quick_alu #(.W(W)) u_quick (
    .op (op),
    .a  (a),
    .b  (b),
    .y  (quick_y)
  );

  always_comb begin
    result_d = result_q;
    done_d   = 1'b0;
    if (fast_fire) begin
      result_d = quick_y;
      done_d   = 1'b1;
    end else if (pow_finish) begin
      result_d = pow_acc;
      done_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= done_d;
      if (done_d) result_q <= result_d;
    end
  end

  assign result = result_q;
  assign done   = done_q;
endmodule

// File: rtl/fu_top_chk.sv
module fu_top_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [1:0]   op,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [W-1:0] result,
  input logic         done,
  input logic         busy,
  input logic         cnt_zero,
  input logic [W-2:0] cnt
);
  localparam logic [W-2:0] DEC = (W-1)'(1);
  localparam logic [W-1:0] ONE = W'(1);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  // R8
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(!busy && start && (op != 2'b00)) || $past(busy && cnt_zero)));

  // R7
  pow_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cnt_zero) |=> (busy && !done && (cnt == $past(cnt) - DEC)));

  // R9
  busy_ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cnt_zero && start) |=> busy);

  // R2
  add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (op == 2'b01)) |=> (done && (result == $past(a + b))));

  // R3
  or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (op == 2'b10)) |=> (done && (result == $past(a | b))));

  // R4
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (op == 2'b11)) |=> (done && (result == $past(a))));

  // R6
  zero_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (op == 2'b00) && (b[W-2:0] == '0)) |=> ##1 (done && (result == ONE)));
endmodule

bind fu_top fu_top_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .op       (op),
  .a        (a),
  .b        (b),
  .result   (result),
  .done     (done),
  .busy     (busy),
  .cnt_zero (cnt_zero),
  .cnt      (pow_cnt)
);

// File: tb/fu_top_bench.sv
module fu_top_bench;
  logic clk;
  logic rst_n;

  logic       start4, start8;
  logic [1:0] op4, op8;
  logic [3:0] a4, b4, res4;
  logic [7:0] a8, b8, res8;
  logic       done4, done8;

  int n_tests;
  int n_fail;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  fu_top #(.W(4)) u_fu_top (
    .clk(clk), .rst_n(rst_n), .start(start4), .op(op4),
    .a(a4), .b(b4), .result(res4), .done(done4)
  );

  fu_top #(.W(8)) u_fu_top_w8 (
    .clk(clk), .rst_n(rst_n), .start(start8), .op(op8),
    .a(a8), .b(b8), .result(res8), .done(done8)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_res(input int w, input int op, input int a, input int b);
    int mask = (1 << w) - 1;
    int e    = b & ((1 << (w - 1)) - 1);
    int r    = 1;
    case (op)
      0: begin
        for (int i = 0; i < e; i++) r = (r * a) & mask;
        return r;
      end
      1: return (a + b) & mask;
      2: return (a | b) & mask;
      default: return a & mask;
    endcase
  endfunction

  function automatic string req_of(input int op, input int w, input int b);
    case (op)
      0: return ((b & ((1 << (w - 1)) - 1)) == 0) ? "R6 R9" : "R5 R9";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic drive(input int w, input bit st, input int op, input int a, input int b);
    if (w == 4) begin
      start4 = st; op4 = 2'(op); a4 = 4'(a); b4 = 4'(b);
    end else begin
      start8 = st; op8 = 2'(op); a8 = 8'(a); b8 = 8'(b);
    end
  endtask

  function automatic bit get_done(input int w);
    return (w == 4) ? done4 : done8;
  endfunction

  function automatic int get_res(input int w);
    return (w == 4) ? int'(res4) : int'(res8);
  endfunction

  task automatic do_op(input int w, input int op, input int a, input int b);
    int mask = (1 << w) - 1;
    int er   = exp_res(w, op, a, b);
    int el   = (op == 0) ? (b & ((1 << (w - 1)) - 1)) + 1 : 0;
    int k    = 0;
    int held;
    @(negedge clk);
    drive(w, 1'b1, op, a, b);
    @(negedge clk);
    while (!get_done(w) && k < 400) begin
      // R9: start stays high, operands scrambled while busy
      drive(w, 1'b1, 1, (~a) & mask, (~b) & mask);
      @(negedge clk);
      k++;
    end
    drive(w, 1'b0, 0, 0, 0);
    check(get_res(w) == er, req_of(op, w, b), get_res(w), er);
    check(k == el, "R7", k, el);
    held = get_res(w);
    @(negedge clk);
    check(get_done(w) == 1'b0, "R8", int'(get_done(w)), 0);
    check(get_res(w) == held, "R8", get_res(w), held);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int bl8[6];
    int bp8[6];
    n_tests = 0;
    n_fail  = 0;
    rst_n   = 1'b0;
    drive(4, 1'b0, 0, 0, 0);
    drive(8, 1'b0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(res4 == 4'd0 && done4 == 1'b0, "R1", int'(res4), 0);
    check(res8 == 8'd0 && done8 == 1'b0, "R1", int'(res8), 0);
    rst_n = 1'b1;

    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          do_op(4, op, a, b);

    bl8 = '{0, 1, 127, 128, 255, 90};
    bp8 = '{0, 1, 2, 3, 127, 131};
    for (int op = 1; op < 4; op++)
      for (int a = 0; a < 256; a++)
        foreach (bl8[i]) do_op(8, op, a, bl8[i]);
    for (int a = 0; a < 256; a++)
      foreach (bp8[i]) do_op(8, 0, a, bp8[i]);

    // R1: asynchronous reset in the middle of a long power run
    do_op(8, 1, 5, 6);
    @(negedge clk);
    drive(8, 1'b1, 0, 3, 127);
    repeat (5) @(negedge clk);
    drive(8, 1'b0, 0, 0, 0);
    #5 rst_n = 1'b0;
    #1;
    check(res8 == 8'd0, "R1", int'(res8), 0);
    check(done8 == 1'b0, "R1", int'(done8), 0);
    @(negedge clk);
    rst_n = 1'b1;
    do_op(8, 1, 200, 100);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule